// File: doc/BRIEF.md
# DMA Burst Boundary Splitter

This block sits beside one DMA channel. It turns a programmed transfer into the bus transactions that carry it. When a start pulse arrives, it captures the following settings:

- a source address and a destination address;
- a byte count and a transfer-size code;
- a signed per-transaction increment for each side;
- three mode bits.

It then emits two independent streams of transactions, one for the source side and one for the destination side. Each transaction carries an address, a length in bytes and a burst flag, and is offered with a valid/ready handshake.

Bursts are used only for the two multi-doubleword sizes, and only when the channel's FIFO path is enabled. A burst never crosses a 256-byte address boundary. A size-mode bit picks how bursts are cut:

- **Mode 1:** repeats the configured burst length and trims only at boundaries.
- **Mode 0:** issues the largest naturally aligned power-of-two piece the address allows.

Without bursting, the block issues single accesses of at most one doubleword.

Before anything is issued, the settings are checked against alignment and increment rules. A bad combination is reported with a one-cycle error flag instead of running. When both streams have consumed the whole byte count, a one-cycle done pulse is raised.

Top module: `dma_burst_splitter`

## Requirements
- R1: With a non-negative increment in single-access mode, a side is rejected when its address is not aligned to the access unit. The alignment rules per size code are:
  - code 0 (1 byte): any address;
  - code 1 (2 bytes): bit 0 clear;
  - code 2 (4 bytes): bits 1:0 clear;
  - codes 3 (8 bytes), 4 (32 bytes) and 5 (64 bytes) without the FIFO path: bits 2:0 clear.
- R2: The following are also rejected:
  - a size code of 6 or 7;
  - a negative (two's complement, 8-bit) increment with an 8-byte access unit, unless address bits 2:0 are 111;
  - a negative increment on either side in burst mode.
- R3: When destination burst inhibit is set, the destination increment must be 8, 0 or -8, or the settings are rejected.
- R4: On rejected settings, cfg_err is high for exactly the cycle after the start cycle. In that case busy stays low, no transaction is offered and no done pulse follows.
- R5: Burst mode is in force exactly when the size code is 4 or 5 and fifo_en is set. Every transaction's burst flag equals that condition.
- R6: No burst transaction spans a 256-byte boundary: its address modulo 256, plus its length, is at most 256.
- R7: In burst mode with size_mode=1, each length is the minimum of three values: the size (32 or 64), the remaining count, and the bytes left to the next 256-byte boundary.
- R8: In burst mode with size_mode=0, each length is the largest power of two that meets all three conditions:
  - it is no more than the size and no more than the remaining count;
  - the address is a multiple of it;
  - it does not cross the boundary.
- R9: In single-access mode, each length is the minimum of the access unit and the remaining count. The access unit is the size, capped at 8 bytes. The address then advances by the signed increment.
- R10: In burst mode, the address advances by the issued length when the increment is nonzero, and holds when it is zero.
- R11: A transaction whose valid is not accepted keeps valid, address and length unchanged until ready. The two sides progress independently.
- R12: done pulses for one cycle after both sides have issued transactions summing to the byte count. A zero count gives done with no transactions.
- R13: After reset, busy, cfg_err, done and both valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture settings and begin (ignored while busy) |
| cfg_xsize | input | 3 | Size code: 0=1B 1=2B 2=4B 3=8B 4=32B 5=64B |
| cfg_fifo_en | input | 1 | FIFO path enable, allows bursts |
| cfg_size_mode | input | 1 | 1: fixed-size repetition, 0: alignment-driven split |
| cfg_dst_inhibit | input | 1 | Destination burst inhibit |
| src_addr_i | input | AW | Source start address |
| dst_addr_i | input | AW | Destination start address |
| src_inc_i | input | IW | Source signed increment |
| dst_inc_i | input | IW | Destination signed increment |
| byte_count_i | input | CW | Total bytes to move |
| busy | output | 1 | Transfer in progress |
| cfg_err | output | 1 | Settings rejected (one cycle) |
| done | output | 1 | Transfer finished (one cycle) |
| src_valid | output | 1 | Source transaction offered |
| src_ready | input | 1 | Source transaction accepted |
| src_addr | output | AW | Source transaction address |
| src_len | output | 7 | Source transaction length in bytes |
| src_burst | output | 1 | Source transaction is a burst |
| dst_valid | output | 1 | Destination transaction offered |
| dst_ready | input | 1 | Destination transaction accepted |
| dst_addr | output | AW | Destination transaction address |
| dst_len | output | 7 | Destination transaction length in bytes |
| dst_burst | output | 1 | Destination transaction is a burst |

## Verification
The embedded properties watch the following on every cycle:

- every burst stays inside its 256-byte window;
- alignment-mode bursts are aligned powers of two;
- a length never exceeds what remains;
- an offered transaction holds still until accepted;
- an error leaves the block idle;
- done is a lone pulse with nothing offered.

Only the bench's scenarios can show the rest:

- the exact sequence of lengths and addresses;
- the address arithmetic under negative and zero increments;
- which settings are rejected;
- that done arrives only once both sides have moved the full count.

The mixed-offset fixed-size case, and odd starting addresses under alignment mode, are driven as directed cases.

// File: rtl/dmabs_pkg.sv
package dmabs_pkg;

    localparam int unsigned LEN_W = 7;   // longest transaction is 64 bytes

    typedef enum logic [2:0] {
        XS_1B  = 3'd0,
        XS_2B  = 3'd1,
        XS_4B  = 3'd2,
        XS_8B  = 3'd3,
        XS_4DW = 3'd4,
        XS_8DW = 3'd5
    } xsize_e;

    typedef struct packed {
        logic [2:0] xsize;
        logic       fifo_en;
        logic       size_mode;
        logic       dst_inhibit;
    } chan_cfg_t;

    // Bytes moved by one configured transfer unit; zero for reserved codes.
    function automatic logic [LEN_W-1:0] size_bytes(input logic [2:0] xs);
        case (xs)
            XS_1B:   return 7'd1;
            XS_2B:   return 7'd2;
            XS_4B:   return 7'd4;
            XS_8B:   return 7'd8;
            XS_4DW:  return 7'd32;
            XS_8DW:  return 7'd64;
            default: return 7'd0;
        endcase
    endfunction

    // Single-access unit: the size, capped at one doubleword.
    function automatic logic [3:0] unit_bytes(input logic [2:0] xs);
        case (xs)
            XS_1B:   return 4'd1;
            XS_2B:   return 4'd2;
            XS_4B:   return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic burst_ok(input logic [2:0] xs, input logic fifo_en);
        return fifo_en && ((xs == XS_4DW) || (xs == XS_8DW));
    endfunction

    // Largest power of two not above v (v nonzero).
    function automatic logic [LEN_W-1:0] floor_pow2(input logic [LEN_W-1:0] v);
        logic [LEN_W-1:0] r;
        r = '0;
        for (int i = 0; i < LEN_W; i++) begin
            if (v[i]) r = LEN_W'(1) << i;
        end
        return r;
    endfunction

endpackage

// File: rtl/dmabs_align_chk.sv
module dmabs_align_chk (
    input  logic [2:0] xsize,
    input  logic       burst,
    input  logic [2:0] low3,
    input  logic       inc_neg,
    output logic       bad
);
    import dmabs_pkg::*;

    logic [3:0] unit;

    always_comb begin
        unit = unit_bytes(xsize);
        if (burst) begin
            bad = inc_neg;
        end else if (inc_neg && (unit == 4'd8)) begin
            bad = (low3 != 3'b111);
        end else begin
            case (unit)
                4'd1:    bad = 1'b0;
                4'd2:    bad = low3[0];
                4'd4:    bad = |low3[1:0];
                default: bad = |low3;
            endcase
        end
    end

endmodule

// File: rtl/dmabs_cfg_check.sv
module dmabs_cfg_check #(
    parameter int unsigned IW = 8
) (
    input  logic [2:0]          xsize,
    input  logic                fifo_en,
    input  logic                dst_inhibit,
    input  logic [1:0][2:0]     low3,
    input  logic [1:0][IW-1:0]  inc,
    output logic                err
);
    import dmabs_pkg::*;

    localparam logic [IW-1:0] INC_P8 = IW'(8);
    localparam logic [IW-1:0] INC_M8 = ~INC_P8 + IW'(1);

    logic       burst;
    logic [1:0] side_bad;
    logic       inh_bad;

    assign burst = burst_ok(xsize, fifo_en);

    for (genvar g = 0; g < 2; g++) begin : g_side
        dmabs_align_chk u_chk (
            .xsize   (xsize),
            .burst   (burst),
            .low3    (low3[g]),
            .inc_neg (inc[g][IW-1]),
            .bad     (side_bad[g])
        );
    end

    assign inh_bad = dst_inhibit &&
                     !((inc[1] == INC_P8) || (inc[1] == '0) || (inc[1] == INC_M8));

    assign err = (xsize > 3'd5) || (|side_bad) || inh_bad;

endmodule

// File: rtl/dmabs_chunk_calc.sv
module dmabs_chunk_calc #(
    parameter int unsigned CW     = 16,
    parameter int unsigned BND_LG = 8
) (
    input  logic [BND_LG-1:0]             addr_lo,
    input  logic [CW-1:0]                 rem,
    input  logic [2:0]                    xsize,
    input  logic                          burst,
    input  logic                          size_mode,
    output logic [dmabs_pkg::LEN_W-1:0]   len
);
    import dmabs_pkg::*;

    localparam int unsigned BW = BND_LG + 1;

    logic [LEN_W-1:0] sz;
    logic [3:0]       unit;
    logic [LEN_W-1:0] rem_cap;
    logic [BW-1:0]    to_bnd;
    logic [BW-1:0]    low_bit;
    logic [LEN_W-1:0] pow_cap;

    always_comb begin
        sz      = size_bytes(xsize);
        unit    = unit_bytes(xsize);
        rem_cap = (rem > CW'(sz)) ? sz : LEN_W'(rem);
        to_bnd  = (BW'(1) << BND_LG) - {1'b0, addr_lo};
        low_bit = BW'(1) << BND_LG;
        for (int i = BND_LG - 1; i >= 0; i--) begin
            if (addr_lo[i]) low_bit = BW'(1) << i;
        end
        pow_cap = floor_pow2(rem_cap);
    end

    always_comb begin
        if (!burst) begin
            len = (rem > CW'(unit)) ? LEN_W'(unit) : LEN_W'(rem);
        end else if (size_mode) begin
            len = (to_bnd < BW'(rem_cap)) ? LEN_W'(to_bnd) : rem_cap;
        end else begin
            len = (BW'(pow_cap) > low_bit) ? LEN_W'(low_bit) : pow_cap;
        end
    end

endmodule

// File: rtl/dmabs_stream.sv
module dmabs_stream #(
    parameter int unsigned AW     = 32,
    parameter int unsigned CW     = 16,
    parameter int unsigned IW     = 8,
    parameter int unsigned BND_LG = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [AW-1:0]                 ld_addr,
    input  logic [CW-1:0]                 ld_count,
    input  logic [2:0]                    xsize,
    input  logic                          burst,
    input  logic                          size_mode,
    input  logic [IW-1:0]                 inc,
    output logic                          valid,
    input  logic                          ready,
    output logic [AW-1:0]                 addr,
    output logic [dmabs_pkg::LEN_W-1:0]   len
);
    import dmabs_pkg::*;

    localparam int unsigned BW = BND_LG + 1;

    logic [AW-1:0] addr_q;
    logic [CW-1:0] rem_q;
    logic          act_q;
    logic [AW-1:0] addr_nxt;
    logic [AW-1:0] inc_ext;

    dmabs_chunk_calc #(.CW(CW), .BND_LG(BND_LG)) u_calc (
        .addr_lo   (addr_q[BND_LG-1:0]),
        .rem       (rem_q),
        .xsize     (xsize),
        .burst     (burst),
        .size_mode (size_mode),
        .len       (len)
    );

    assign inc_ext = {{(AW-IW){inc[IW-1]}}, inc};

    always_comb begin
        if (burst) addr_nxt = (inc != '0) ? addr_q + AW'(len) : addr_q;
        else       addr_nxt = addr_q + inc_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rem_q  <= '0;
            act_q  <= 1'b0;
        end else if (load) begin
            addr_q <= ld_addr;
            rem_q  <= ld_count;
            act_q  <= (ld_count != '0);
        end else if (act_q && ready) begin
            addr_q <= addr_nxt;
            rem_q  <= rem_q - CW'(len);
            if (rem_q == CW'(len)) act_q <= 1'b0;
        end
    end

    assign valid = act_q;
    assign addr  = addr_q;

    a_r6_no_cross: assert property (@(posedge clk) disable iff (rst)
        valid && burst |-> ({1'b0, addr[BND_LG-1:0]} + BW'(len)) <= (BW'(1) << BND_LG));

    a_r8_pow2_aligned: assert property (@(posedge clk) disable iff (rst)
        valid && burst && !size_mode |->
            $onehot(len) && ((addr[LEN_W-1:0] & (len - 1'b1)) == '0));

    a_r7_len_bound: assert property (@(posedge clk) disable iff (rst)
        valid |-> (len != '0) && (CW'(len) <= rem_q));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        valid && !ready && !load |=> valid && $stable(addr) && $stable(len));

endmodule

// File: rtl/dma_burst_splitter.sv
module dma_burst_splitter #(
    parameter int unsigned AW     = 32,
    parameter int unsigned CW     = 16,
    parameter int unsigned IW     = 8,
    parameter int unsigned BND_LG = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [2:0]                    cfg_xsize,
    input  logic                          cfg_fifo_en,
    input  logic                          cfg_size_mode,
    input  logic                          cfg_dst_inhibit,
    input  logic [AW-1:0]                 src_addr_i,
    input  logic [AW-1:0]                 dst_addr_i,
    input  logic [IW-1:0]                 src_inc_i,
    input  logic [IW-1:0]                 dst_inc_i,
    input  logic [CW-1:0]                 byte_count_i,
    output logic                          busy,
    output logic                          cfg_err,
    output logic                          done,
    output logic                          src_valid,
    input  logic                          src_ready,
    output logic [AW-1:0]                 src_addr,
    output logic [dmabs_pkg::LEN_W-1:0]   src_len,
    output logic                          src_burst,
    output logic                          dst_valid,
    input  logic                          dst_ready,
    output logic [AW-1:0]                 dst_addr,
    output logic [dmabs_pkg::LEN_W-1:0]   dst_len,
    output logic                          dst_burst
);
    import dmabs_pkg::*;

    chan_cfg_t        cfg_q;
    logic [IW-1:0]    src_inc_q;
    logic [IW-1:0]    dst_inc_q;
    logic             busy_q;
    logic             err_q;
    logic             done_q;
    logic             err_now;
    logic             accept;
    logic             load;
    logic             burst_q;
    logic [1:0][2:0]  low3;
    logic [1:0][IW-1:0] incs;

    assign low3[0] = src_addr_i[2:0];
    assign low3[1] = dst_addr_i[2:0];
    assign incs[0] = src_inc_i;
    assign incs[1] = dst_inc_i;

    dmabs_cfg_check #(.IW(IW)) u_check (
        .xsize       (cfg_xsize),
        .fifo_en     (cfg_fifo_en),
        .dst_inhibit (cfg_dst_inhibit),
        .low3        (low3),
        .inc         (incs),
        .err         (err_now)
    );

    assign accept = start && !busy_q;
    assign load   = accept && !err_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            src_inc_q <= '0;
            dst_inc_q <= '0;
            busy_q    <= 1'b0;
            err_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            err_q  <= accept && err_now;
            done_q <= 1'b0;
            if (load) begin
                cfg_q     <= '{xsize: cfg_xsize, fifo_en: cfg_fifo_en,
                               size_mode: cfg_size_mode, dst_inhibit: cfg_dst_inhibit};
                src_inc_q <= src_inc_i;
                dst_inc_q <= dst_inc_i;
                busy_q    <= 1'b1;
            end else if (busy_q && !src_valid && !dst_valid) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    assign burst_q = burst_ok(cfg_q.xsize, cfg_q.fifo_en);

    dmabs_stream #(.AW(AW), .CW(CW), .IW(IW), .BND_LG(BND_LG)) u_src (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .ld_addr   (src_addr_i),
        .ld_count  (byte_count_i),
        .xsize     (cfg_q.xsize),
        .burst     (burst_q),
        .size_mode (cfg_q.size_mode),
        .inc       (src_inc_q),
        .valid     (src_valid),
        .ready     (src_ready),
        .addr      (src_addr),
        .len       (src_len)
    );

    dmabs_stream #(.AW(AW), .CW(CW), .IW(IW), .BND_LG(BND_LG)) u_dst (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .ld_addr   (dst_addr_i),
        .ld_count  (byte_count_i),
        .xsize     (cfg_q.xsize),
        .burst     (burst_q),
        .size_mode (cfg_q.size_mode),
        .inc       (dst_inc_q),
        .valid     (dst_valid),
        .ready     (dst_ready),
        .addr      (dst_addr),
        .len       (dst_len)
    );

    assign src_burst = burst_q;
    assign dst_burst = burst_q;
    assign busy      = busy_q;
    assign cfg_err   = err_q;
    assign done      = done_q;

    a_r4_err_idle: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy && !src_valid && !dst_valid && !done);

    a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r12_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !src_valid && !dst_valid && !busy);

    a_r13_valid_needs_busy: assert property (@(posedge clk) disable iff (rst)
        (src_valid || dst_valid) |-> busy);

endmodule

// File: tb/dma_burst_splitter_bench.sv
module dma_burst_splitter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  cfg_xsize = '0;
    logic        cfg_fifo_en = 1'b0;
    logic        cfg_size_mode = 1'b0;
    logic        cfg_dst_inhibit = 1'b0;
    logic [31:0] src_addr_i = '0;
    logic [31:0] dst_addr_i = '0;
    logic [7:0]  src_inc_i = '0;
    logic [7:0]  dst_inc_i = '0;
    logic [15:0] byte_count_i = '0;
    logic        busy, cfg_err, done;
    logic        src_valid, dst_valid, src_burst, dst_burst;
    logic        src_ready = 1'b0;
    logic        dst_ready = 1'b0;
    logic [31:0] src_addr, dst_addr;
    logic [6:0]  src_len, dst_len;

    always #5 clk = ~clk;

    dma_burst_splitter u_dma_burst_splitter (
        .clk(clk), .rst(rst), .start(start),
        .cfg_xsize(cfg_xsize), .cfg_fifo_en(cfg_fifo_en),
        .cfg_size_mode(cfg_size_mode), .cfg_dst_inhibit(cfg_dst_inhibit),
        .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
        .src_inc_i(src_inc_i), .dst_inc_i(dst_inc_i),
        .byte_count_i(byte_count_i),
        .busy(busy), .cfg_err(cfg_err), .done(done),
        .src_valid(src_valid), .src_ready(src_ready), .src_addr(src_addr),
        .src_len(src_len), .src_burst(src_burst),
        .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_addr(dst_addr),
        .dst_len(dst_len), .dst_burst(dst_burst)
    );

    int n_checks = 0;
    int n_fails  = 0;

    // model state per side (0 = source, 1 = destination)
    bit [31:0] m_addr [2];
    int        m_rem  [2];
    int        m_inc  [2];
    int        m_xs;
    bit        m_burst, m_mode;
    bit        h_pend [2];
    bit [31:0] h_addr [2];
    int        h_len  [2];
    int        hs_cnt [2];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int size_of(input int xs);
        case (xs)
            0: return 1;  1: return 2;  2: return 4;
            3: return 8;  4: return 32; 5: return 64;
            default: return 0;
        endcase
    endfunction

    function automatic int unit_of(input int xs);
        int s = size_of(xs);
        return (s == 0 || s > 8) ? 8 : s;
    endfunction

    function automatic string err_tag(input int xs, input bit f, input bit inh,
                                      input bit [31:0] sa, input bit [31:0] da,
                                      input int si, input int di);
        bit        bm;
        bit [31:0] a;
        int        inc, u;
        if (xs > 5) return "R2";
        if (inh && !(di == 8 || di == 0 || di == -8)) return "R3";
        bm = f && (xs == 4 || xs == 5);
        u  = unit_of(xs);
        for (int s = 0; s < 2; s++) begin
            a   = (s == 0) ? sa : da;
            inc = (s == 0) ? si : di;
            if (bm) begin
                if (inc < 0) return "R2";
            end else if (inc < 0 && u == 8) begin
                if (a[2:0] != 3'b111) return "R2";
            end else if ((a % u) != 0) begin
                return "R1";
            end
        end
        return "";
    endfunction

    function automatic int exp_len(input bit [31:0] a, input int rem);
        int c, p, tb, cap;
        if (!m_burst) begin
            c = unit_of(m_xs);
            return (rem < c) ? rem : c;
        end
        if (m_mode) begin
            c  = size_of(m_xs);
            tb = 256 - int'(a[7:0]);
            if (rem < c) c = rem;
            if (tb < c) c = tb;
            return c;
        end
        cap = size_of(m_xs);
        if (rem < cap) cap = rem;
        p = 64;
        while (p > cap) p = p / 2;
        while ((a % p) != 0) p = p / 2;
        return p;
    endfunction

    task automatic observe(input int s, input bit v, input bit r,
                           input bit [31:0] a, input int len, input bit b);
        int    el;
        string tg;
        if (h_pend[s]) begin
            check(v && a == h_addr[s] && len == h_len[s], "R11", "held transaction",
                  a, h_addr[s]);
        end
        h_pend[s] = v && !r;
        h_addr[s] = a;
        h_len[s]  = len;
        if (v && r) begin
            if (m_rem[s] == 0) begin
                check(1'b0, "R12", "transaction beyond count", len, 0);
                return;
            end
            el = exp_len(m_addr[s], m_rem[s]);
            tg = !m_burst ? "R9" : (m_mode ? "R7" : "R8");
            check(len == el, tg, "length", len, el);
            check(a == m_addr[s], m_burst ? "R10" : "R9", "address", a, m_addr[s]);
            check(b == m_burst, "R5", "burst flag", b, m_burst);
            if (b) check(int'(a[7:0]) + len <= 256, "R6", "boundary", int'(a[7:0]) + len, 256);
            hs_cnt[s]++;
            m_rem[s] = m_rem[s] - el;
            if (m_burst) begin
                if (m_inc[s] != 0) m_addr[s] = m_addr[s] + 32'(el);
            end else begin
                m_addr[s] = m_addr[s] + 32'(m_inc[s]);
            end
        end
    endtask

    task automatic run_case(input int xs, input bit f, input bit m, input bit inh,
                            input bit [31:0] sa, input bit [31:0] da,
                            input int si, input int di, input int cnt);
        string et;
        int    cyc;
        bit    fin;
        @(negedge clk);
        cfg_xsize = 3'(xs); cfg_fifo_en = f; cfg_size_mode = m; cfg_dst_inhibit = inh;
        src_addr_i = sa; dst_addr_i = da; src_inc_i = 8'(si); dst_inc_i = 8'(di);
        byte_count_i = 16'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        et = err_tag(xs, f, inh, sa, da, si, di);
        check(cfg_err == (et != ""), (et != "") ? et : "R1", "cfg_err", cfg_err, et != "");
        hs_cnt[0] = 0; hs_cnt[1] = 0;
        if (et != "") begin
            check(!busy && !src_valid && !dst_valid, "R4", "idle on error",
                  {busy, src_valid, dst_valid}, 0);
            @(negedge clk);
            check(!cfg_err && !done, "R4", "error pulse width / no done", {cfg_err, done}, 0);
            return;
        end
        check(busy == 1'b1, "R12", "busy after start", busy, 1);
        m_xs = xs; m_burst = f && (xs == 4 || xs == 5); m_mode = m;
        m_addr[0] = sa; m_addr[1] = da; m_rem[0] = cnt; m_rem[1] = cnt;
        m_inc[0] = si; m_inc[1] = di;
        h_pend[0] = 1'b0; h_pend[1] = 1'b0;
        cyc = 0; fin = 1'b0;
        while (!fin) begin
            if (done) begin
                check(m_rem[0] == 0 && m_rem[1] == 0, "R12", "done with bytes left",
                      m_rem[0] + m_rem[1], 0);
                fin = 1'b1;
            end else begin
                src_ready = ($urandom % 4) != 0;
                dst_ready = ($urandom % 4) != 0;
                #1;
                observe(0, src_valid, src_ready, src_addr, int'(src_len), src_burst);
                observe(1, dst_valid, dst_ready, dst_addr, int'(dst_len), dst_burst);
                @(negedge clk);
                cyc++;
                if (cyc > 4000) begin
                    check(1'b0, "R12", "no done", 0, 1);
                    fin = 1'b1;
                end
            end
        end
        src_ready = 1'b0;
        dst_ready = 1'b0;
        @(negedge clk);
        check(!done, "R12", "done one cycle", done, 0);
    endtask

    function automatic int pick_inc(input int u);
        case ($urandom % 6)
            0: return 0;
            1: return -u;
            2: return int'($urandom % 256) - 128;
            default: return u;
        endcase
    endfunction

    function automatic int pick_dst3();
        case ($urandom % 4)
            0: return 8;
            1: return 0;
            2: return -8;
            default: return int'($urandom % 256) - 128;
        endcase
    endfunction

    function automatic bit [31:0] align_to(input bit [31:0] a, input int u, input int inc);
        bit [31:0] r = a & ~(32'(u) - 32'd1);
        if (inc < 0 && u == 8) r = r | 32'd7;
        return r;
    endfunction

    task automatic rand_case();
        int        xs, u, si, di, cnt;
        bit        f, m, inh;
        bit [31:0] sa, da;
        xs  = ($urandom % 16 == 0) ? 6 + int'($urandom % 2) : int'($urandom % 6);
        f   = ($urandom % 4) != 0;
        m   = $urandom % 2;
        inh = ($urandom % 4) == 0;
        u   = unit_of(xs);
        si  = pick_inc(u);
        di  = inh ? pick_dst3() : pick_inc(u);
        sa  = $urandom;
        da  = $urandom;
        if ($urandom % 4 != 0) sa = align_to(sa, u, si);
        if ($urandom % 4 != 0) da = align_to(da, u, di);
        cnt = ($urandom % 8 == 0) ? 0 : int'($urandom % 300);
        run_case(xs, f, m, inh, sa, da, si, di, cnt);
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'h1d5a_0c37);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        check(!busy && !cfg_err && !done && !src_valid && !dst_valid, "R13", "reset outputs",
              {busy, cfg_err, done, src_valid, dst_valid}, 0);

        // R7 mixed offsets, fixed-size repetition: five bursts per side
        run_case(5, 1, 1, 0, 32'h0000_10A8, 32'h0000_2038, 8, 8, 256);
        check(hs_cnt[0] == 5, "R7", "source burst count", hs_cnt[0], 5);
        check(hs_cnt[1] == 5, "R7", "destination burst count", hs_cnt[1], 5);
        // R8 odd start under alignment mode: 1,4,8,16,32,32,4,2,1
        run_case(5, 1, 0, 0, 32'h0000_0003, 32'h0000_0040, 8, 8, 100);
        check(hs_cnt[0] == 9, "R8", "source piece count", hs_cnt[0], 9);
        // R10 zero increment in burst mode
        run_case(4, 1, 1, 0, 32'h0000_00F0, 32'h0000_0100, 0, 8, 80);
        // R9 short tail and negative single increment
        run_case(1, 0, 0, 0, 32'h0000_0010, 32'h0000_0020, 2, -2, 5);
        run_case(3, 0, 0, 0, 32'h0000_0107, 32'h0000_0200, -8, 8, 24);
        // R9 multi-doubleword size without FIFO path
        run_case(5, 0, 1, 0, 32'h0000_0008, 32'h0000_0010, 8, 8, 40);
        // R12 zero count
        run_case(2, 0, 0, 0, 32'h0, 32'h0, 4, 4, 0);
        // R1 / R2 / R3 rejections
        run_case(1, 0, 0, 0, 32'h0000_0001, 32'h0, 2, 2, 8);
        run_case(3, 0, 0, 0, 32'h0000_0100, 32'h0, -8, 8, 8);
        run_case(4, 1, 0, 0, 32'h0, 32'h0, -8, 8, 64);
        run_case(6, 0, 0, 0, 32'h0, 32'h0, 1, 1, 8);
        run_case(3, 0, 0, 1, 32'h0, 32'h0, 8, 16, 8);

        for (int i = 0; i < 120; i++) rand_case();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule